// File: doc/BRIEF.md
# Row-Grouped Dirty-Bit Index

This block keeps the dirty status of a writeback cache in a table of its own, apart from the main tag store. Each table entry stands for one memory row segment and holds a row tag and a vector with one dirty flag per cache block of that segment. The table is set-associative. A block is dirty exactly when a valid entry in its set carries the block's row tag and the flag at the block's position in the row is set.

Three operations arrive on one request port, one per cycle. A writeback-insert marks a block dirty. An eviction query reports whether a block was dirty and clears its flag. A plain query only reports. When an insert needs a new entry in a set with every way in use, the entry that was written least recently is displaced. Its row number and whole flag vector are presented on a valid/ready victim port so that every block it marks can be written back. Those blocks stay in the cache and become clean. While that victim waits, the request port takes no new operation. Every accepted operation returns the block's dirty status as it was before the operation, a fixed number of cycles later.

Top module: `dirty_row_index`

## Requirements
- R1: After reset every block reads clean, `vic_valid` and `rsp_valid` are low and `req_ready` is high.
- R2: `req_addr` is a block address. The low log2(GRAN) bits are the position in the row, the next log2(SETS) bits select the set, and the remaining high bits are the row tag. Blocks that differ only in position share one entry.
- R3: An insert (`req_op` = 1) for a row with no entry allocates one in which only that block's flag is set. Other blocks of the row, and the same position in other sets or rows, read clean.
- R4: An insert for a row that already has an entry sets that block's flag and leaves the entry's other flags unchanged. Its response is 1 if the block was already dirty.
- R5: An eviction query (`req_op` = 2) responds with the block's prior status and clears its flag. Other flags of the entry are kept.
- R6: When an eviction query clears the last flag of an entry, the entry is freed, and a later new row in that set takes the freed way without displacing anything.
- R7: A plain query (`req_op` = 0, or 3, which behaves identically) reports the status and changes no state.
- R8: An insert of a new row into a set whose ways are all valid displaces the entry whose last insert is oldest. Only inserts count as writes for this order; queries and eviction queries do not.
- R9: A displaced entry appears on `vic_valid` with `vic_row` = {row tag, set index} and `vic_bits` equal to its full flag vector, held unchanged until `vic_ready` is high. Its blocks then read clean, and the new row's block reads dirty.
- R10: While `vic_valid` is high, `req_ready` is low and no operation is accepted.
- R11: An operation accepted at a clock edge produces `rsp_valid` high for one cycle after the LAT-th edge counted from and including that edge, with `rsp_dirty` equal to the block's status before the operation.
- R12: Sets are independent: operations in one set do not alter the dirty status of blocks in another set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | Operation can be accepted this cycle |
| req_op | input | 2 | 0 query, 1 insert, 2 eviction query, 3 query |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | Result of an earlier operation |
| rsp_dirty | output | 1 | Block was dirty before that operation |
| vic_valid | output | 1 | Displaced entry waiting for writeback |
| vic_ready | input | 1 | Consumer takes the displaced entry |
| vic_row | output | ADDR_W-log2(GRAN) | Row number of the displaced entry |
| vic_bits | output | GRAN | Dirty flags of the displaced entry |

## Verification
The hardest case is a displacement whose victim is not simply the oldest allocation. Writing order must have been changed by a repeat insert into an older row, and queries must have been aimed at the row that should lose, so that a design updating recency on reads picks the wrong way. The stimulus first frees a way through eviction queries, fills the set again, re-touches one row by insert, queries another, and only then inserts a fresh row. It then holds `vic_ready` low for several cycles to watch the victim and the stalled request port.

// File: rtl/dri_pkg.sv
package dri_pkg;

    typedef enum logic [1:0] {
        OP_QUERY     = 2'd0,
        OP_INSERT    = 2'd1,
        OP_CLEAN     = 2'd2,
        OP_QUERY_ALT = 2'd3
    } dri_op_e;

    // Result word carried through the response delay line
    typedef struct packed {
        logic valid;
        logic dirty;
    } dri_rsp_t;

endpackage

// File: rtl/dri_way_match.sv
module dri_way_match #(
    parameter int WAYS   = 16,
    parameter int TAG_W  = 20,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [WAYS-1:0][RANK_W-1:0] ranks,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [RANK_W-1:0]           hit_way,
    output logic                        has_free,
    output logic [RANK_W-1:0]           free_way,
    output logic [RANK_W-1:0]           old_way
);
    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        has_free = 1'b0;
        free_way = '0;
        old_way  = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (vld[i] && tags[i] == key) begin
                hit     = 1'b1;
                hit_way = RANK_W'(i);
            end
            if (ranks[i] == OLDEST) begin
                old_way = RANK_W'(i);
            end
        end
        // scan downwards so the lowest free way wins
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                has_free = 1'b1;
                free_way = RANK_W'(i);
            end
        end
    end
endmodule

// File: rtl/dri_lrw_touch.sv
module dri_lrw_touch #(
    parameter int WAYS   = 16,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][RANK_W-1:0] ranks_in,
    input  logic [RANK_W-1:0]           way,
    output logic [WAYS-1:0][RANK_W-1:0] ranks_out
);
    // rank 0 = most recently written, WAYS-1 = oldest
    logic [RANK_W-1:0] pivot;

    always_comb begin
        pivot = ranks_in[way];
        for (int i = 0; i < WAYS; i++) begin
            if (RANK_W'(i) == way) begin
                ranks_out[i] = '0;
            end else if (ranks_in[i] < pivot) begin
                ranks_out[i] = ranks_in[i] + RANK_W'(1);
            end else begin
                ranks_out[i] = ranks_in[i];
            end
        end
    end
endmodule

// File: rtl/dri_rsp_delay.sv
module dri_rsp_delay
    import dri_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  dri_rsp_t in_rsp,
    output dri_rsp_t out_rsp
);
    generate
        if (LAT == 1) begin : g_single
            dri_rsp_t stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= in_rsp;
            end
            assign out_rsp = stage_q;
        end else begin : g_chain
            dri_rsp_t stage_q [LAT];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= in_rsp;
                    for (int i = 1; i < LAT; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign out_rsp = stage_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/dirty_row_index.sv
module dirty_row_index
    import dri_pkg::*;
#(
    parameter int ADDR_W = 34,
    parameter int GRAN   = 64,
    parameter int WAYS   = 16,
    parameter int SETS   = 4,
    parameter int LAT    = 4
) (
    input  logic                                 clk,
    input  logic                                rst,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [1:0]                          req_op,
    input  logic [ADDR_W-1:0]                   req_addr,
    output logic                                rsp_valid,
    output logic                                rsp_dirty,
    output logic                                vic_valid,
    input  logic                                vic_ready,
    output logic [ADDR_W-$clog2(GRAN)-1:0]      vic_row,
    output logic [GRAN-1:0]                     vic_bits
);
    localparam int OFF_W  = $clog2(GRAN);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int ROW_W  = ADDR_W - OFF_W;
    localparam int RANK_W = $clog2(WAYS);

    // table storage
    logic [WAYS-1:0]             ent_vld  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  ent_tag  [SETS];
    logic [WAYS-1:0][GRAN-1:0]   ent_bits [SETS];
    logic [WAYS-1:0][RANK_W-1:0] ent_rank [SETS];

    // address fields
    logic [OFF_W-1:0] a_off;
    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;
    assign a_off = req_addr[OFF_W-1:0];
    assign a_set = req_addr[OFF_W +: SET_W];
    assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

    dri_op_e op;
    assign op = dri_op_e'(req_op);

    logic accept;
    assign req_ready = !vic_valid;
    assign accept    = req_valid && req_ready;

    // lookup in the addressed set
    logic                        hit, has_free;
    logic [RANK_W-1:0]           hit_way, free_way, old_way, alloc_way, tgt_way;
    logic [WAYS-1:0][RANK_W-1:0] touched;

    dri_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .RANK_W(RANK_W)) u_match (
        .vld      (ent_vld[a_set]),
        .tags     (ent_tag[a_set]),
        .ranks    (ent_rank[a_set]),
        .key      (a_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .has_free (has_free),
        .free_way (free_way),
        .old_way  (old_way)
    );

    assign alloc_way = has_free ? free_way : old_way;
    assign tgt_way   = hit ? hit_way : alloc_way;

    dri_lrw_touch #(.WAYS(WAYS), .RANK_W(RANK_W)) u_touch (
        .ranks_in  (ent_rank[a_set]),
        .way       (tgt_way),
        .ranks_out (touched)
    );

    logic [GRAN-1:0] cur_bits, off_mask, cleared;
    logic            was_dirty;

    always_comb begin
        cur_bits  = hit ? ent_bits[a_set][hit_way] : '0;
        off_mask  = GRAN'(1) << a_off;
        was_dirty = hit && cur_bits[a_off];
        cleared   = cur_bits & ~off_mask;
    end

    // state update at the accept edge
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                ent_vld[s]  <= '0;
                ent_tag[s]  <= '0;
                ent_bits[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    ent_rank[s][w] <= RANK_W'(w);
                end
            end
            vic_valid <= 1'b0;
            vic_row   <= '0;
            vic_bits  <= '0;
        end else begin
            if (vic_valid && vic_ready) begin
                vic_valid <= 1'b0;
            end
            if (accept) begin
                case (op)
                    OP_INSERT: begin
                        if (hit) begin
                            ent_bits[a_set][hit_way] <= cur_bits | off_mask;
                        end else begin
                            if (!has_free) begin
                                vic_valid <= 1'b1;
                                vic_row   <= {ent_tag[a_set][old_way], a_set};
                                vic_bits  <= ent_bits[a_set][old_way];
                            end
                            ent_vld[a_set][alloc_way]  <= 1'b1;
                            ent_tag[a_set][alloc_way]  <= a_tag;
                            ent_bits[a_set][alloc_way] <= off_mask;
                        end
                        ent_rank[a_set] <= touched;
                    end
                    OP_CLEAN: begin
                        if (was_dirty) begin
                            ent_bits[a_set][hit_way] <= cleared;
                            if (cleared == '0) begin
                                ent_vld[a_set][hit_way] <= 1'b0;
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // fixed-latency result
    dri_rsp_t rsp_in, rsp_out;
    assign rsp_in.valid = accept;
    assign rsp_in.dirty = accept && was_dirty;

    dri_rsp_delay #(.LAT(LAT)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .in_rsp  (rsp_in),
        .out_rsp (rsp_out)
    );

    assign rsp_valid = rsp_out.valid;
    assign rsp_dirty = rsp_out.dirty;

endmodule

// File: rtl/dri_checker.sv
module dri_checker #(
    parameter int ROW_W = 28,
    parameter int GRAN  = 64,
    parameter int LAT   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_op,
    input logic             rsp_valid,
    input logic             vic_valid,
    input logic             vic_ready,
    input logic [ROW_W-1:0] vic_row,
    input logic [GRAN-1:0]  vic_bits
);
    localparam int CNT_W = $clog2(LAT + 1) + 1;

    logic [CNT_W-1:0] pending;
    logic             acc;
    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= pending + CNT_W'(acc) - CNT_W'(rsp_valid);
    end

    a_r10_stall: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> !req_ready);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        vic_valid && !vic_ready |=> vic_valid && $stable(vic_row) && $stable(vic_bits));

    a_r9_nonempty: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> vic_bits != '0);

    a_r8_from_insert: assert property (@(posedge clk) disable iff (rst)
        $rose(vic_valid) |-> $past(req_valid && req_ready && req_op == 2'd1));

    a_r11_no_orphan: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> pending != '0);

    a_r11_bounded: assert property (@(posedge clk) disable iff (rst)
        pending <= CNT_W'(LAT));

endmodule

bind dirty_row_index dri_checker #(
    .ROW_W (ADDR_W - $clog2(GRAN)),
    .GRAN  (GRAN),
    .LAT   (LAT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .vic_row   (vic_row),
    .vic_bits  (vic_bits)
);

// File: tb/dirty_row_index_test.sv
module dirty_row_index_test;
    localparam int ADDR_W = 8;
    localparam int GRAN   = 4;
    localparam int WAYS   = 4;
    localparam int SETS   = 2;
    localparam int LAT    = 4;
    localparam int ROW_W  = ADDR_W - 2;

    localparam logic [1:0] Q  = 2'd0;
    localparam logic [1:0] IN = 2'd1;
    localparam logic [1:0] EV = 2'd2;
    localparam logic [1:0] Q3 = 2'd3;

    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_ready;
    logic [1:0] req_op;
    logic [ADDR_W-1:0] req_addr;
    logic rsp_valid, rsp_dirty;
    logic vic_valid, vic_ready;
    logic [ROW_W-1:0] vic_row;
    logic [GRAN-1:0] vic_bits;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dirty_row_index #(
        .ADDR_W(ADDR_W), .GRAN(GRAN), .WAYS(WAYS), .SETS(SETS), .LAT(LAT)
    ) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_dirty(rsp_dirty),
        .vic_valid(vic_valid), .vic_ready(vic_ready),
        .vic_row(vic_row), .vic_bits(vic_bits)
    );

    function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
        return {t[4:0], s[0], o[1:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // issue one operation and check its delayed response (R11)
    task automatic do_op(input logic [1:0] op, input int t, input int s, input int o,
                         input logic exp, input string req);
        @(negedge clk);
        check("R10 ready before op", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = mk(t, s, o);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (LAT - 2) @(posedge clk);
        @(negedge clk);
        check("R11 no early response", 32'(rsp_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        check("R11 response valid", 32'(rsp_valid), 32'd1);
        check(req, 32'(rsp_dirty), 32'(exp));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; vic_ready = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 no victim", 32'(vic_valid), 32'd0);
        check("R1 no response", 32'(rsp_valid), 32'd0);
        for (int a = 0; a < 256; a++) begin
            do_op(Q, a >> 3, (a >> 2) & 1, a & 3, 1'b0, "R1 all clean sweep");
        end

        // R3 allocate new row
        do_op(IN, 3, 0, 2, 1'b0, "R3 insert new row reports clean");
        for (int o = 0; o < 4; o++) begin
            do_op(Q, 3, 0, o, (o == 2), "R2 R3 only inserted block dirty");
        end
        do_op(Q, 3, 1, 2, 1'b0, "R12 other set clean");
        do_op(Q, 4, 0, 2, 1'b0, "R3 other row clean");

        // R4 update existing row
        do_op(IN, 3, 0, 0, 1'b0, "R4 insert into existing row");
        do_op(Q, 3, 0, 2, 1'b1, "R4 earlier flag kept");
        do_op(Q, 3, 0, 0, 1'b1, "R4 new flag set");
        do_op(IN, 3, 0, 0, 1'b1, "R4 repeat insert reports dirty");

        // R7 plain queries do not change state
        do_op(Q, 3, 0, 2, 1'b1, "R7 query once");
        do_op(Q3, 3, 0, 2, 1'b1, "R7 code 3 acts as query");
        do_op(Q, 3, 0, 2, 1'b1, "R7 still dirty");

        // R5 eviction query
        do_op(EV, 3, 0, 2, 1'b1, "R5 clean reports prior dirty");
        do_op(Q, 3, 0, 2, 1'b0, "R5 flag cleared");
        do_op(Q, 3, 0, 0, 1'b1, "R5 sibling flag kept");
        do_op(EV, 3, 0, 2, 1'b0, "R5 second clean reports clean");
        do_op(EV, 3, 0, 0, 1'b1, "R6 clear last flag");
        do_op(Q, 3, 0, 0, 1'b0, "R6 row now clean");

        // fill set 0 with four rows
        do_op(IN, 10, 0, 1, 1'b0, "R3 fill row 10");
        do_op(IN, 11, 0, 0, 1'b0, "R3 fill row 11");
        do_op(IN, 11, 0, 3, 1'b0, "R4 row 11 second block");
        do_op(IN, 12, 0, 2, 1'b0, "R3 fill row 12");
        do_op(IN, 13, 0, 1, 1'b0, "R3 fill row 13");
        check("R6 no victim while ways free", 32'(vic_valid), 32'd0);
        do_op(Q, 13, 1, 1, 1'b0, "R12 set 1 untouched");

        // free row 10's way, then reuse it
        do_op(EV, 10, 0, 1, 1'b1, "R6 clear row 10 last flag");
        do_op(IN, 14, 0, 2, 1'b0, "R6 insert into freed way");
        check("R6 freed way reused without victim", 32'(vic_valid), 32'd0);

        // recency: re-touch row 11 by insert, query and clean-probe row 12
        do_op(IN, 11, 0, 1, 1'b0, "R8 re-write row 11");
        do_op(Q, 12, 0, 2, 1'b1, "R8 query row 12");
        do_op(EV, 12, 0, 0, 1'b0, "R8 clean probe on clean block of row 12");
        do_op(IN, 15, 0, 3, 1'b0, "R8 insert into full set");
        check("R9 victim presented", 32'(vic_valid), 32'd1);
        check("R8 victim is row 12", 32'(vic_row), 32'(12 * 2 + 0));
        check("R9 victim flag vector", 32'(vic_bits), 32'b0100);
        check("R10 port stalled", 32'(req_ready), 32'd0);
        // attempt an op while stalled; it must not be taken
        @(negedge clk);
        req_valid = 1'b1; req_op = IN; req_addr = mk(20, 0, 0);
        repeat (3) @(negedge clk);
        check("R9 victim held", 32'(vic_valid), 32'd1);
        check("R9 victim row stable", 32'(vic_row), 32'd24);
        check("R10 still stalled", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        check("R10 stalled op gave no response", 32'(rsp_valid), 32'd0);
        vic_ready = 1'b1;
        @(negedge clk);
        vic_ready = 1'b0;
        check("R9 victim released", 32'(vic_valid), 32'd0);
        check("R10 ready again", 32'(req_ready), 32'd1);
        do_op(Q, 20, 0, 0, 1'b0, "R10 stalled insert had no effect");
        do_op(Q, 12, 0, 2, 1'b0, "R9 victim block clean");
        do_op(Q, 15, 0, 3, 1'b1, "R9 new row dirty");
        do_op(Q, 11, 0, 1, 1'b1, "R8 recent row kept");
        do_op(Q, 11, 0, 3, 1'b1, "R8 recent row kept all flags");
        do_op(Q, 13, 0, 1, 1'b1, "R8 row 13 kept");
        do_op(Q, 14, 0, 2, 1'b1, "R8 row 14 kept");
        do_op(Q, 12, 1, 2, 1'b0, "R12 set 1 still clean");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule